// File: doc/BRIEF.md
# Interrupt and Abort Routing Unit

This unit decides, each cycle it is free, whether one of three asynchronous event classes is to be taken: the normal interrupt, the fast interrupt, or the external abort. For each class it combines the request line, the processor mask for that class, the current security state, a per-class monitor-routing bit, and, for the fast interrupt and the external abort only, a mask-control bit and a hypervisor override bit. Each class then either qualifies or not, and the highest-priority qualifying class wins. The unit records the winner and whether it goes to the monitor or to its native handler mode.

The result is registered. It is held unchanged until the consumer pulses an acknowledge. A small state machine has two states. `ST_IDLE` means no event is held. On any qualifying class, the transition *capture* moves it to `ST_HOLD` and latches the winner. In `ST_HOLD` the transition *release* is taken on `ack` and returns to `ST_IDLE` with the outputs cleared. Without `ack`, the transition *stay* keeps everything. In `ST_IDLE` with nothing qualifying, the transition *wait* keeps it idle.

The encoding is the same on every vector port. Bit 0 is the normal interrupt, bit 1 the fast interrupt and bit 2 the external abort. The two-bit control ports use bit 0 for the fast interrupt and bit 1 for the external abort. A processor mask bit of 1 means masked. A routing bit of 1 means the monitor.

Top module: `evt_route_unit`

## Requirements
- R1: After reset `take_o` is 3'b000 and `to_monitor_o` is 0.
- R2: `to_monitor_o` equals the routing bit of the captured class: 1 sends it to the monitor and 0 to its native mode.
- R3: A normal interrupt is captured only when its processor mask bit (`pmask[0]`) is 0, whatever the security state.
- R4: Take a fast interrupt or external abort whose routing bit is 1, whose hypervisor override is 0 and whose mask-control bit is 0. If the core is non-secure (`nonsec`=1), the event is captured even when its processor mask is 1, and it goes to the monitor.
- R5: Under the same routing, override and mask-control settings, a fast interrupt or external abort in secure state (`nonsec`=0) is blocked when its processor mask is 1.
- R6: With routing bit 1, override 0 and mask-control 1, a fast interrupt or external abort is blocked by its processor mask in both security states. When unmasked, it is captured and goes to the monitor.
- R7: When the routing bit is 0 or the hypervisor override is 1, the mask-control bit has no effect and the processor mask alone decides.
- R8: When several classes qualify together, exactly one `take_o` bit is set: the external abort first, then the fast interrupt, then the normal interrupt.
- R9: While an event is held and `ack` is low, `take_o` and `to_monitor_o` stay unchanged whatever the other inputs do.
- R10: `ack` high at a clock edge while an event is held clears both outputs after that edge. No new event is captured at that same edge.
- R11: `ack` while nothing is held has no effect, and a qualifying event is still captured at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 3 | Event request lines (irq, fiq, abort) |
| pmask | input | 3 | Processor mask bits, 1 = masked |
| route | input | 3 | Monitor routing bits, 1 = monitor |
| mask_ctl | input | 2 | Mask-control bits for fiq and abort |
| hv_ovr | input | 2 | Hypervisor override bits for fiq and abort |
| nonsec | input | 1 | Current security state, 1 = non-secure |
| ack | input | 1 | Acknowledge pulse releasing the held event |
| take_o | output | 3 | One-hot taken event, zero when none |
| to_monitor_o | output | 1 | Held event goes to the monitor |

## Verification
The bench targets a masked non-secure fast interrupt or abort under monitor routing with mask-control clear. A design that always honoured the mask would drop that event. The same setting in secure state must stay blocked, and a design that ignored the security state would wrongly take it. Further cases cover mask-control with routing off or the override set, where a design applying the exemption without both guards would take masked events. Simultaneous requests expose a wrong priority order. Changing the inputs during a hold exposes outputs that are not truly latched. An `ack` at the edge where requests are present catches a design that captures again at the release edge.

// File: rtl/evr_pkg.sv
package evr_pkg;
    localparam int NCLS    = 3;
    localparam int NCTL    = NCLS - 1;
    localparam int IDX_IRQ = 0;
    localparam int IDX_FIQ = 1;
    localparam int IDX_ABT = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } evr_state_e;
endpackage

// File: rtl/evr_qualify.sv
module evr_qualify #(
    parameter bit HAS_CTL = 1'b1
) (
    input  logic req,
    input  logic pmask,
    input  logic route,
    input  logic mctl,
    input  logic hovr,
    input  logic nonsec,
    output logic elig
);
    logic exempt;

    // Non-secure exemption from the mask: monitor routing, no override, control clear
    always_comb begin
        exempt = HAS_CTL && route && !hovr && !mctl && nonsec;
        elig   = req && (exempt || !pmask);
    end
endmodule

// File: rtl/evr_pick.sv
module evr_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] elig,
    output logic [N-1:0] win,
    output logic         any
);
    // Highest index has highest priority
    always_comb begin
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i] && (win == '0)) begin
                win[i] = 1'b1;
            end
        end
        any = |elig;
    end
endmodule

// File: rtl/evt_route_unit.sv
module evt_route_unit
    import evr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] req,
    input  logic [NCLS-1:0] pmask,
    input  logic [NCLS-1:0] route,
    input  logic [NCTL-1:0] mask_ctl,
    input  logic [NCTL-1:0] hv_ovr,
    input  logic            nonsec,
    input  logic            ack,
    output logic [NCLS-1:0] take_o,
    output logic            to_monitor_o
);
    evr_state_e      st, st_n;
    logic [NCLS-1:0] elig;
    logic [NCLS-1:0] win;
    logic            any;
    logic            dest_mon;

    for (genvar g = 0; g < NCLS; g++) begin : g_qual
        if (g == IDX_IRQ) begin : g_plain
            evr_qualify #(.HAS_CTL(1'b0)) u_q (
                .req(req[g]), .pmask(pmask[g]), .route(route[g]),
                .mctl(1'b0), .hovr(1'b0), .nonsec(nonsec), .elig(elig[g])
            );
        end else begin : g_ctl
            evr_qualify #(.HAS_CTL(1'b1)) u_q (
                .req(req[g]), .pmask(pmask[g]), .route(route[g]),
                .mctl(mask_ctl[g-1]), .hovr(hv_ovr[g-1]), .nonsec(nonsec),
                .elig(elig[g])
            );
        end
    end

    evr_pick #(.N(NCLS)) u_pick (
        .elig(elig),
        .win (win),
        .any (any)
    );

    assign dest_mon = |(win & route);

    // Next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE: if (any) st_n = ST_HOLD;
            ST_HOLD: if (ack) st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o       <= '0;
            to_monitor_o <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (any) begin
                    take_o       <= win;
                    to_monitor_o <= dest_mon;
                end
                ST_HOLD: if (ack) begin
                    take_o       <= '0;
                    to_monitor_o <= 1'b0;
                end
            endcase
        end
    end

    assert_onehot_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_o));

    assert_abt_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && elig[IDX_ABT]) |=> take_o == 3'b100);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !ack) |=> ($stable(take_o) && $stable(to_monitor_o)));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && ack) |=> (take_o == '0 && !to_monitor_o));

    assert_irq_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && pmask[IDX_IRQ]) |=> !take_o[IDX_IRQ]);

    assert_ns_exempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && req[IDX_ABT] && route[IDX_ABT] && !hv_ovr[1]
         && !mask_ctl[1] && nonsec) |=> (take_o[IDX_ABT] && to_monitor_o));
endmodule

// File: tb/sim_evt_route_unit.sv
module sim_evt_route_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] req, pmask, route;
    logic [1:0] mask_ctl, hv_ovr;
    logic       nonsec, ack;
    logic [2:0] take_o;
    logic       to_monitor_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    evt_route_unit u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .pmask(pmask), .route(route),
        .mask_ctl(mask_ctl), .hv_ovr(hv_ovr), .nonsec(nonsec), .ack(ack),
        .take_o(take_o), .to_monitor_o(to_monitor_o)
    );

    function automatic bit ref_elig(bit rq, bit msk, bit rt, bit ctl, bit ovr,
                                    bit ns, bit has_ctl);
        if (!rq) return 1'b0;
        if (has_ctl && rt && !ovr && !ctl && ns) return 1'b1;
        return !msk;
    endfunction

    // Expected {to_monitor, take[2:0]}
    function automatic logic [3:0] ref_out(logic [2:0] rq, logic [2:0] pm,
            logic [2:0] rt, logic [1:0] mc, logic [1:0] ov, logic ns);
        bit e0, e1, e2;
        e0 = ref_elig(rq[0], pm[0], rt[0], 1'b0, 1'b0, ns, 1'b0);
        e1 = ref_elig(rq[1], pm[1], rt[1], mc[0], ov[0], ns, 1'b1);
        e2 = ref_elig(rq[2], pm[2], rt[2], mc[1], ov[1], ns, 1'b1);
        if (e2) return {rt[2], 3'b100};
        if (e1) return {rt[1], 3'b010};
        if (e0) return {rt[0], 3'b001};
        return 4'b0000;
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(logic [2:0] rq, logic [2:0] pm, logic [2:0] rt,
                         logic [1:0] mc, logic [1:0] ov, logic ns);
        req = rq; pmask = pm; route = rt; mask_ctl = mc; hv_ovr = ov; nonsec = ns;
    endtask

    // Called at a negedge in idle; drives, captures, checks, releases
    task automatic run_case(string tag, logic [2:0] rq, logic [2:0] pm,
            logic [2:0] rt, logic [1:0] mc, logic [1:0] ov, logic ns,
            logic [3:0] exp);
        logic [3:0] model;
        drive(rq, pm, rt, mc, ov, ns);
        model = ref_out(rq, pm, rt, mc, ov, ns);
        @(posedge clk); @(negedge clk);
        check({tag, " model"}, model, exp);
        check(tag, {to_monitor_o, take_o}, exp);
        if (exp[2:0] != 3'b000) begin
            ack = 1'b1;
            @(posedge clk); @(negedge clk);
            ack = 1'b0;
            check("R10 release", {to_monitor_o, take_o}, 4'b0000);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; ack = 1'b0;
        drive(3'b111, 3'b000, 3'b111, 2'b00, 2'b00, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {to_monitor_o, take_o}, 4'b0000);
        drive(3'b000, 3'b000, 3'b000, 2'b00, 2'b00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases
        run_case("R4 ns fiq masked exempt", 3'b010, 3'b010, 3'b010, 2'b00, 2'b00, 1'b1, 4'b1010);
        run_case("R4 ns abt masked exempt", 3'b100, 3'b100, 3'b100, 2'b00, 2'b00, 1'b1, 4'b1100);
        run_case("R5 s fiq masked blocked", 3'b010, 3'b010, 3'b010, 2'b00, 2'b00, 1'b0, 4'b0000);
        run_case("R5 s abt masked blocked", 3'b100, 3'b100, 3'b100, 2'b00, 2'b00, 1'b0, 4'b0000);
        run_case("R6 ctl ns fiq masked", 3'b010, 3'b010, 3'b010, 2'b01, 2'b00, 1'b1, 4'b0000);
        run_case("R6 ctl ns abt unmasked", 3'b100, 3'b000, 3'b100, 2'b10, 2'b00, 1'b1, 4'b1100);
        run_case("R7 ovr ns fiq masked", 3'b010, 3'b010, 3'b010, 2'b00, 2'b01, 1'b1, 4'b0000);
        run_case("R7 route0 ns abt masked", 3'b100, 3'b100, 3'b000, 2'b00, 2'b00, 1'b1, 4'b0000);
        run_case("R2 R7 route0 fiq native", 3'b010, 3'b000, 3'b000, 2'b00, 2'b00, 1'b1, 4'b0010);
        run_case("R3 irq masked ns", 3'b001, 3'b001, 3'b001, 2'b00, 2'b00, 1'b1, 4'b0000);
        run_case("R2 irq monitor", 3'b001, 3'b000, 3'b001, 2'b00, 2'b00, 1'b0, 4'b1001);
        run_case("R8 all three", 3'b111, 3'b000, 3'b011, 2'b00, 2'b00, 1'b0, 4'b0100);
        run_case("R8 fiq over irq", 3'b011, 3'b000, 3'b001, 2'b00, 2'b00, 1'b0, 4'b0010);

        // R9 hold with changing inputs, R10 no capture at release edge
        drive(3'b001, 3'b000, 3'b000, 2'b00, 2'b00, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R9 captured", {to_monitor_o, take_o}, 4'b0001);
        drive(3'b111, 3'b000, 3'b111, 2'b00, 2'b00, 1'b1);
        @(posedge clk); @(negedge clk);
        check("R9 held", {to_monitor_o, take_o}, 4'b0001);
        ack = 1'b1;
        @(posedge clk); @(negedge clk);
        ack = 1'b0;
        check("R10 no capture at release", {to_monitor_o, take_o}, 4'b0000);
        @(posedge clk); @(negedge clk);
        check("R10 capture after release", {to_monitor_o, take_o}, 4'b1100);
        ack = 1'b1;
        @(posedge clk); @(negedge clk);
        ack = 1'b0;
        drive(3'b000, 3'b000, 3'b000, 2'b00, 2'b00, 1'b0);

        // R11 ack in idle ignored
        ack = 1'b1;
        drive(3'b010, 3'b000, 3'b010, 2'b00, 2'b00, 1'b0);
        @(posedge clk); @(negedge clk);
        ack = 1'b0;
        check("R11 ack idle", {to_monitor_o, take_o}, 4'b1010);
        ack = 1'b1;
        @(posedge clk); @(negedge clk);
        ack = 1'b0;
        drive(3'b000, 3'b000, 3'b000, 2'b00, 2'b00, 1'b0);

        // Random stimulus checked against the model (R2..R9)
        for (int n = 0; n < 400; n++) begin
            logic [2:0] rq, pm, rt;
            logic [1:0] mc, ov;
            logic ns;
            logic [3:0] exp;
            rq = 3'($urandom); pm = 3'($urandom); rt = 3'($urandom);
            mc = 2'($urandom); ov = 2'($urandom); ns = 1'($urandom);
            exp = ref_out(rq, pm, rt, mc, ov, ns);
            drive(rq, pm, rt, mc, ov, ns);
            @(posedge clk); @(negedge clk);
            check("R2-model random", {to_monitor_o, take_o}, exp);
            if (exp[2:0] != 3'b000) begin
                drive(3'($urandom), 3'($urandom), 3'($urandom),
                      2'($urandom), 2'($urandom), 1'($urandom));
                @(posedge clk); @(negedge clk);
                check("R9 random hold", {to_monitor_o, take_o}, exp);
                ack = 1'b1;
                @(posedge clk); @(negedge clk);
                ack = 1'b0;
                check("R10 random release", {to_monitor_o, take_o}, 4'b0000);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule